// File: doc/BRIEF.md
# Flash LED driver I2C register file

This block is the serial control front end of a flash LED driver. It acts as an I2C target and holds four byte-wide control registers: a command register, a dimming register, an auxiliary LED register and a status register. A two-bit strap input chooses one of four 7-bit target addresses. A host transaction sends the target address, then a register pointer, then data bytes. For reads, the host sets the pointer and then issues a repeated start with the read bit set. The pointer steps forward after every data byte in both directions.

Bit 7 of the command register decides whether the driver is awake. While it is 0 the driver is in shutdown. In shutdown only the command register can be reached. Writing the command register with bit 7 cleared also wipes the dimming and auxiliary registers. The status register mirrors fault bits from the rest of the controller. After the host has clocked out a status byte, the block sends a one-cycle pulse so that the fault latches can clear.

The block works on SCL and SDA samples that have already been synchronised to its clock. It returns a single pull-low request for the SDA pad.

Top module: `ledi2c_regs`

## Requirements
- R1: After reset the command, dimming and auxiliary outputs are 0x00. SDA is not pulled low and no status-read pulse is issued.
- R2: The block acknowledges a target address byte only when its upper seven bits equal 0x30 plus the strap value (strap 00 gives 0x30, 01 gives 0x31, 10 gives 0x32, 11 gives 0x33). Any other address gets no acknowledge, and the rest of that transaction changes no register.
- R3: In a write transaction (address byte bit 0 = 0), the byte after the address loads the pointer. Each later byte is written to the pointer, after which the pointer steps forward. The block acknowledges every byte, and it only changes its SDA pull while SCL is low.
- R4: In a read transaction, started by a repeated start with address bit 0 = 1, each byte is returned MSB first from the pointer, and the pointer steps forward after each byte. Once the host answers a byte with NACK, the block stops driving SDA.
- R5: The pointer steps from 0x03 back to 0x00. Above 0x03 it counts up by one and wraps from 0xFF to 0x00. Pointers above 0x03 are acknowledged, read as 0x00 and ignore writes.
- R6: The status register (pointer 0x03) cannot be written: writes to it are acknowledged and have no effect. While awake, a read of it returns the status input.
- R7: While command bit 7 is 0, reads of pointers 0x01 to 0x03 return 0x00 and writes to 0x01 and 0x02 are ignored. The command register (pointer 0x00) can always be read and written.
- R8: Writing the command register with bit 7 = 0 clears the dimming and auxiliary registers and the status register. The command register keeps the value that was written.
- R9: Reading a status byte while awake produces exactly one single-cycle status-read pulse, after the eighth data bit. A status read in shutdown produces none.
- R10: The command, dimming and auxiliary outputs always show the current contents of their registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| scl_i | input | 1 | Synchronised SCL sample |
| sda_i | input | 1 | Synchronised SDA sample (wired line level) |
| sda_pull_o | output | 1 | Request to pull SDA low |
| addr_sel_i | input | 2 | Address strap: 00 ground, 01 supply, 10 tied to SDA, 11 tied to SCL |
| status_i | input | 8 | Fault and state bits from the controller |
| cmd_o | output | 8 | Command register contents |
| dim_o | output | 8 | Dimming register contents |
| aux_o | output | 8 | Auxiliary LED register contents |
| status_read_o | output | 1 | One-cycle pulse after a status byte has been read |

## Verification
The hardest case to reach is a multi-byte burst that crosses a mode change partway through. One example is a write that starts at pointer 0 with command bit 7 cleared and then goes on into the dimming and auxiliary registers, where those later bytes must be ignored. Another is a read that walks past the status register and wraps back to the command register. The stimulus mixes directed bursts for these cases with random transactions. The random transactions draw the start pointer from 0 to 5, the burst length, the strap, the direction and the command mode bit, and they sometimes use a wrong address. A register model in the bench predicts every byte read back and every status-read pulse.

// File: rtl/ledi2c_pkg.sv
package ledi2c_pkg;

  localparam int BYTE_W  = 8;
  localparam int PTR_W   = 8;
  localparam int STRAP_W = 2;
  localparam int DEV_W   = 7;

  localparam logic [PTR_W-1:0] PTR_CMD  = 8'h00;
  localparam logic [PTR_W-1:0] PTR_DIM  = 8'h01;
  localparam logic [PTR_W-1:0] PTR_AUX  = 8'h02;
  localparam logic [PTR_W-1:0] PTR_STAT = 8'h03;

  localparam int AWAKE_BIT = BYTE_W - 1;

  typedef enum logic [3:0] {
    S_IDLE,
    S_ADDR,
    S_ADDR_ACK,
    S_REG,
    S_REG_ACK,
    S_WDATA,
    S_WDATA_ACK,
    S_RDATA,
    S_RACK
  } tgt_state_t;

  function automatic logic [PTR_W-1:0] ptr_step(input logic [PTR_W-1:0] p);
    if (p == PTR_STAT) return PTR_CMD;
    return p + PTR_W'(1);
  endfunction

endpackage

// File: rtl/ledi2c_rst_sync.sv
module ledi2c_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  generate
    if (STAGES <= 1) begin : g_single
      logic q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= 1'b0;
        else        q <= 1'b1;
      end
      assign rst_sync_n = q;
    end else begin : g_chain
      logic [STAGES-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= {q[STAGES-2:0], 1'b1};
      end
      assign rst_sync_n = q[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/ledi2c_bus_cond.sv
module ledi2c_bus_cond (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);

  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  assign scl_rise  =  scl_i & ~scl_q;
  assign scl_fall  = ~scl_i &  scl_q;
  // SDA moving while SCL stays high marks a bus condition
  assign start_det =  scl_i &  scl_q &  sda_q & ~sda_i;
  assign stop_det  =  scl_i &  scl_q & ~sda_q &  sda_i;

endmodule

// File: rtl/ledi2c_target_fsm.sv
module ledi2c_target_fsm
  import ledi2c_pkg::*;
#(
  parameter logic [DEV_W-1:0] DEV_BASE = 7'h30
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sda_i,
  input  logic                 scl_rise,
  input  logic                 scl_fall,
  input  logic                 start_det,
  input  logic                 stop_det,
  input  logic [STRAP_W-1:0]   strap_i,
  input  logic [BYTE_W-1:0]    rd_data_i,
  output logic [PTR_W-1:0]     ptr_o,
  output logic                 wr_en_o,
  output logic [PTR_W-1:0]     wr_ptr_o,
  output logic [BYTE_W-1:0]    wr_data_o,
  output logic                 rd_done_o,
  output logic [PTR_W-1:0]     rd_ptr_o,
  output logic                 sda_pull_o
);

  localparam int CNT_W = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

  tgt_state_t          state_q, state_d;
  logic [CNT_W-1:0]    cnt_q, cnt_d;
  logic                done_q, done_d;
  logic [BYTE_W-1:0]   sh_q, sh_d;
  logic [BYTE_W-1:0]   tx_q, tx_d;
  logic [PTR_W-1:0]    ptr_q, ptr_d;
  logic                rw_q, rw_d;
  logic                mack_q, mack_d;
  logic                wr_en_q, wr_en_d;
  logic [PTR_W-1:0]    wr_ptr_q, wr_ptr_d;
  logic [BYTE_W-1:0]   wr_data_q, wr_data_d;
  logic                rd_done_q, rd_done_d;
  logic [PTR_W-1:0]    rd_ptr_q, rd_ptr_d;
  logic [DEV_W-1:0]    dev_addr;

  assign dev_addr = DEV_BASE + DEV_W'(strap_i);

  always_comb begin
    state_d   = state_q;
    cnt_d     = cnt_q;
    done_d    = done_q;
    sh_d      = sh_q;
    tx_d      = tx_q;
    ptr_d     = ptr_q;
    rw_d      = rw_q;
    mack_d    = mack_q;
    wr_en_d   = 1'b0;
    wr_ptr_d  = wr_ptr_q;
    wr_data_d = wr_data_q;
    rd_done_d = 1'b0;
    rd_ptr_d  = rd_ptr_q;
    if (stop_det) begin
      state_d = S_IDLE;
    end else if (start_det) begin
      state_d = S_ADDR;
      cnt_d   = '0;
      done_d  = 1'b0;
    end else begin
      unique case (state_q)
        S_ADDR, S_REG, S_WDATA: begin
          if (scl_rise) begin
            sh_d  = {sh_q[BYTE_W-2:0], sda_i};
            cnt_d = cnt_q + CNT_W'(1);
            if (cnt_q == LAST_BIT) done_d = 1'b1;
          end else if (scl_fall && done_q) begin
            done_d = 1'b0;
            if (state_q == S_ADDR) begin
              if (sh_q[BYTE_W-1:1] == dev_addr) begin
                rw_d    = sh_q[0];
                state_d = S_ADDR_ACK;
              end else begin
                state_d = S_IDLE;
              end
            end else if (state_q == S_REG) begin
              ptr_d   = sh_q;
              state_d = S_REG_ACK;
            end else begin
              wr_en_d   = 1'b1;
              wr_ptr_d  = ptr_q;
              wr_data_d = sh_q;
              ptr_d     = ptr_step(ptr_q);
              state_d   = S_WDATA_ACK;
            end
          end
        end
        S_ADDR_ACK: begin
          if (scl_fall) begin
            cnt_d = '0;
            if (rw_q) begin
              tx_d    = rd_data_i;
              state_d = S_RDATA;
            end else begin
              state_d = S_REG;
            end
          end
        end
        S_REG_ACK, S_WDATA_ACK: begin
          if (scl_fall) begin
            cnt_d   = '0;
            state_d = S_WDATA;
          end
        end
        S_RDATA: begin
          if (scl_rise) begin
            cnt_d = cnt_q + CNT_W'(1);
            if (cnt_q == LAST_BIT) done_d = 1'b1;
          end else if (scl_fall) begin
            if (done_q) begin
              done_d    = 1'b0;
              rd_done_d = 1'b1;
              rd_ptr_d  = ptr_q;
              ptr_d     = ptr_step(ptr_q);
              state_d   = S_RACK;
            end else begin
              tx_d = {tx_q[BYTE_W-2:0], 1'b0};
            end
          end
        end
        S_RACK: begin
          if (scl_rise) begin
            mack_d = ~sda_i;
          end else if (scl_fall) begin
            cnt_d = '0;
            if (mack_q) begin
              tx_d    = rd_data_i;
              state_d = S_RDATA;
            end else begin
              state_d = S_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= S_IDLE;
      cnt_q     <= '0;
      done_q    <= 1'b0;
      sh_q      <= '0;
      tx_q      <= '0;
      ptr_q     <= '0;
      rw_q      <= 1'b0;
      mack_q    <= 1'b0;
      wr_en_q   <= 1'b0;
      wr_ptr_q  <= '0;
      wr_data_q <= '0;
      rd_done_q <= 1'b0;
      rd_ptr_q  <= '0;
    end else begin
      state_q   <= state_d;
      cnt_q     <= cnt_d;
      done_q    <= done_d;
      sh_q      <= sh_d;
      tx_q      <= tx_d;
      ptr_q     <= ptr_d;
      rw_q      <= rw_d;
      mack_q    <= mack_d;
      wr_en_q   <= wr_en_d;
      wr_ptr_q  <= wr_ptr_d;
      wr_data_q <= wr_data_d;
      rd_done_q <= rd_done_d;
      rd_ptr_q  <= rd_ptr_d;
    end
  end

  assign ptr_o      = ptr_q;
  assign wr_en_o    = wr_en_q;
  assign wr_ptr_o   = wr_ptr_q;
  assign wr_data_o  = wr_data_q;
  assign rd_done_o  = rd_done_q;
  assign rd_ptr_o   = rd_ptr_q;
  assign sda_pull_o = (state_q == S_ADDR_ACK) || (state_q == S_REG_ACK) ||
                      (state_q == S_WDATA_ACK) ||
                      ((state_q == S_RDATA) && !tx_q[BYTE_W-1]);

endmodule

// File: rtl/ledi2c_reg_bank.sv
module ledi2c_reg_bank
  import ledi2c_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en_i,
  input  logic [PTR_W-1:0]    wr_ptr_i,
  input  logic [BYTE_W-1:0]   wr_data_i,
  input  logic [PTR_W-1:0]    rd_ptr_i,
  input  logic                rd_done_i,
  input  logic [PTR_W-1:0]    rd_done_ptr_i,
  input  logic [BYTE_W-1:0]   status_i,
  output logic [BYTE_W-1:0]   rd_data_o,
  output logic [BYTE_W-1:0]   cmd_o,
  output logic [BYTE_W-1:0]   dim_o,
  output logic [BYTE_W-1:0]   aux_o,
  output logic                status_read_o
);

  logic [BYTE_W-1:0] cmd_q, cmd_d, dim_q, dim_d, aux_q, aux_d, stat_q, stat_d;
  logic              sread_q, sread_d;
  logic              cmd_en, dim_en, aux_en;
  logic              awake, awake_next, sleep_entry;

  assign awake       = cmd_q[AWAKE_BIT];
  assign cmd_en      = wr_en_i && (wr_ptr_i == PTR_CMD);
  assign sleep_entry = cmd_en && !wr_data_i[AWAKE_BIT];
  assign dim_en      = sleep_entry || (wr_en_i && awake && (wr_ptr_i == PTR_DIM));
  assign aux_en      = sleep_entry || (wr_en_i && awake && (wr_ptr_i == PTR_AUX));

  always_comb begin
    cmd_d      = wr_data_i;
    dim_d      = sleep_entry ? '0 : wr_data_i;
    aux_d      = sleep_entry ? '0 : wr_data_i;
    awake_next = cmd_en ? wr_data_i[AWAKE_BIT] : awake;
    stat_d     = awake_next ? status_i : '0;
    sread_d    = rd_done_i && awake && (rd_done_ptr_i == PTR_STAT);
  end

  always_comb begin
    unique case (rd_ptr_i)
      PTR_CMD:  rd_data_o = cmd_q;
      PTR_DIM:  rd_data_o = awake ? dim_q  : '0;
      PTR_AUX:  rd_data_o = awake ? aux_q  : '0;
      PTR_STAT: rd_data_o = awake ? stat_q : '0;
      default:  rd_data_o = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q   <= '0;
      dim_q   <= '0;
      aux_q   <= '0;
      stat_q  <= '0;
      sread_q <= 1'b0;
    end else begin
      if (cmd_en) cmd_q <= cmd_d;
      if (dim_en) dim_q <= dim_d;
      if (aux_en) aux_q <= aux_d;
      stat_q  <= stat_d;
      sread_q <= sread_d;
    end
  end

  assign cmd_o         = cmd_q;
  assign dim_o         = dim_q;
  assign aux_o         = aux_q;
  assign status_read_o = sread_q;

endmodule

// File: rtl/ledi2c_regs.sv
module ledi2c_regs
  import ledi2c_pkg::*;
#(
  parameter logic [DEV_W-1:0] DEV_BASE   = 7'h30,
  parameter int               RST_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               scl_i,
  input  logic               sda_i,
  output logic               sda_pull_o,
  input  logic [STRAP_W-1:0] addr_sel_i,
  input  logic [BYTE_W-1:0]  status_i,
  output logic [BYTE_W-1:0]  cmd_o,
  output logic [BYTE_W-1:0]  dim_o,
  output logic [BYTE_W-1:0]  aux_o,
  output logic               status_read_o
);

  logic              rst_int_n;
  logic              scl_rise, scl_fall, start_det, stop_det;
  logic [PTR_W-1:0]  ptr, wr_ptr, rd_done_ptr;
  logic              wr_en, rd_done;
  logic [BYTE_W-1:0] wr_data, rd_data;

  ledi2c_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  ledi2c_bus_cond u_cond (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  ledi2c_target_fsm #(.DEV_BASE(DEV_BASE)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .sda_i      (sda_i),
    .scl_rise   (scl_rise),
    .scl_fall   (scl_fall),
    .start_det  (start_det),
    .stop_det   (stop_det),
    .strap_i    (addr_sel_i),
    .rd_data_i  (rd_data),
    .ptr_o      (ptr),
    .wr_en_o    (wr_en),
    .wr_ptr_o   (wr_ptr),
    .wr_data_o  (wr_data),
    .rd_done_o  (rd_done),
    .rd_ptr_o   (rd_done_ptr),
    .sda_pull_o (sda_pull_o)
  );

  ledi2c_reg_bank u_bank (
    .clk           (clk),
    .rst_n         (rst_int_n),
    .wr_en_i       (wr_en),
    .wr_ptr_i      (wr_ptr),
    .wr_data_i     (wr_data),
    .rd_ptr_i      (ptr),
    .rd_done_i     (rd_done),
    .rd_done_ptr_i (rd_done_ptr),
    .status_i      (status_i),
    .rd_data_o     (rd_data),
    .cmd_o         (cmd_o),
    .dim_o         (dim_o),
    .aux_o         (aux_o),
    .status_read_o (status_read_o)
  );

endmodule

// File: rtl/ledi2c_regs_chk.sv
module ledi2c_regs_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_i,
  input logic       sda_pull_o,
  input logic [7:0] cmd_o,
  input logic [7:0] dim_o,
  input logic [7:0] aux_o,
  input logic       status_read_o
);

  // R8
  sleep_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_o[7] |-> (dim_o == 8'h00 && aux_o == 8'h00));

  // R7
  dim_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(dim_o) |-> $past(cmd_o[7]));

  // R7
  aux_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(aux_o) |-> $past(cmd_o[7]));

  // R9
  sread_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    status_read_o |=> !status_read_o);

  // R9
  sread_awake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    status_read_o |-> cmd_o[7]);

  // R3
  pull_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_pull_o) |-> !scl_i);

endmodule

bind ledi2c_regs ledi2c_regs_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .scl_i         (scl_i),
  .sda_pull_o    (sda_pull_o),
  .cmd_o         (cmd_o),
  .dim_o         (dim_o),
  .aux_o         (aux_o),
  .status_read_o (status_read_o)
);

// File: tb/ledi2c_regs_tb.sv
`timescale 1ns/1ps
module ledi2c_regs_tb;

  localparam int H = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl_m = 1'b1;
  logic       sda_m = 1'b1;
  logic       sda_line;
  logic       sda_pull;
  logic [1:0] strap = 2'b00;
  logic [7:0] stat_in = 8'h00;
  logic [7:0] cmd_o, dim_o, aux_o;
  logic       sread;

  int checks = 0;
  int errors = 0;
  int sr_seen = 0;
  int sr_exp = 0;
  bit done = 1'b0;

  logic [7:0] m_cmd = 8'h00, m_dim = 8'h00, m_aux = 8'h00, m_ptr = 8'h00;

  always #2 clk = ~clk;

  assign sda_line = sda_m & ~sda_pull;

  ledi2c_regs u_dut (
    .clk           (clk),
    .rst_n         (rst_n),
    .scl_i         (scl_m),
    .sda_i         (sda_line),
    .sda_pull_o    (sda_pull),
    .addr_sel_i    (strap),
    .status_i      (stat_in),
    .cmd_o         (cmd_o),
    .dim_o         (dim_o),
    .aux_o         (aux_o),
    .status_read_o (sread)
  );

  always @(posedge clk) if (rst_n && sread) sr_seen++;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] step(input logic [7:0] p);
    return (p == 8'h03) ? 8'h00 : p + 8'h01;
  endfunction

  function automatic logic [7:0] m_read(input logic [7:0] p);
    case (p)
      8'h00:   return m_cmd;
      8'h01:   return m_cmd[7] ? m_dim : 8'h00;
      8'h02:   return m_cmd[7] ? m_aux : 8'h00;
      8'h03:   return m_cmd[7] ? stat_in : 8'h00;
      default: return 8'h00;
    endcase
  endfunction

  task automatic m_write(input logic [7:0] p, input logic [7:0] d);
    if (p == 8'h00) begin
      m_cmd = d;
      if (!d[7]) begin m_dim = 8'h00; m_aux = 8'h00; end
    end else if (p == 8'h01 && m_cmd[7]) m_dim = d;
    else if (p == 8'h02 && m_cmd[7]) m_aux = d;
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; tick(H); scl_m = 1'b1; tick(H);
    sda_m = 1'b0; tick(H); scl_m = 1'b0; tick(H);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; tick(H); scl_m = 1'b1; tick(H);
    sda_m = 1'b1; tick(H);
  endtask

  task automatic wr_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; tick(H); scl_m = 1'b1; tick(H); scl_m = 1'b0; tick(H);
    end
    sda_m = 1'b1; tick(H); scl_m = 1'b1; tick(H/2);
    ack = ~sda_line;
    tick(H/2); scl_m = 1'b0; tick(H);
  endtask

  task automatic rd_byte(input logic give_ack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      tick(H); scl_m = 1'b1; tick(H/2); b[i] = sda_line; tick(H/2); scl_m = 1'b0;
    end
    sda_m = give_ack ? 1'b0 : 1'b1;
    tick(H); scl_m = 1'b1; tick(H); scl_m = 1'b0; sda_m = 1'b1; tick(H);
  endtask

  task automatic check_outputs(input string tag);
    chk({tag, " R10 cmd_o"}, cmd_o, m_cmd);
    chk({tag, " R8 dim_o"}, dim_o, m_dim);
    chk({tag, " R8 aux_o"}, aux_o, m_aux);
  endtask

  // write burst: pointer then n data bytes
  task automatic do_write(input logic [6:0] dev, input bit good, input logic [7:0] p,
                          input int n, input logic [7:0] d0, input logic [7:0] d1,
                          input logic [7:0] d2, input logic [7:0] d3);
    logic ack;
    logic [7:0] d;
    bus_start();
    wr_byte({dev, 1'b0}, ack);
    chk("R2 address ack", ack, good);
    if (!good) begin
      wr_byte(p, ack);
      chk("R2 ignored after mismatch", ack, 1'b0);
      bus_stop();
      check_outputs("R2 unchanged");
      return;
    end
    wr_byte(p, ack);
    chk("R3 pointer ack", ack, 1'b1);
    m_ptr = p;
    for (int i = 0; i < n; i++) begin
      d = (i == 0) ? d0 : (i == 1) ? d1 : (i == 2) ? d2 : d3;
      wr_byte(d, ack);
      chk("R3 data ack", ack, 1'b1);
      m_write(m_ptr, d);
      m_ptr = step(m_ptr);
    end
    bus_stop();
    tick(2);
    check_outputs("R3 after write");
  endtask

  task automatic do_read(input logic [6:0] dev, input logic [7:0] p, input int n);
    logic ack;
    logic [7:0] b;
    bus_start();
    wr_byte({dev, 1'b0}, ack);
    chk("R2 address ack", ack, 1'b1);
    wr_byte(p, ack);
    chk("R3 pointer ack", ack, 1'b1);
    m_ptr = p;
    bus_start();
    wr_byte({dev, 1'b1}, ack);
    chk("R4 read address ack", ack, 1'b1);
    for (int i = 0; i < n; i++) begin
      rd_byte(i != n - 1, b);
      if (m_ptr == 8'h03 && m_cmd[7]) sr_exp++;
      if (m_ptr > 8'h03)       chk("R5 high pointer reads zero", b, m_read(m_ptr));
      else if (m_ptr == 8'h03) chk("R6 R7 status read", b, m_read(m_ptr));
      else                     chk("R4 R7 read data", b, m_read(m_ptr));
      m_ptr = step(m_ptr);
    end
    chk("R4 released after NACK", sda_pull, 1'b0);
    bus_stop();
    tick(4);
    chk("R9 status pulse count", sr_seen, sr_exp);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hang expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [6:0] dev;
    void'($urandom(32'h5EED0123));
    tick(5);
    rst_n = 1'b1;
    tick(6);
    // R1 reset state
    chk("R1 cmd reset", cmd_o, 8'h00);
    chk("R1 dim reset", dim_o, 8'h00);
    chk("R1 aux reset", aux_o, 8'h00);
    chk("R1 sda not pulled", sda_pull, 1'b0);
    chk("R1 no status pulse", sr_seen, 0);

    stat_in = 8'h5C;
    // R7 shutdown: dim write ignored, reads zero
    do_write(7'h30, 1'b1, 8'h01, 2, 8'hAA, 8'hBB, 8'h00, 8'h00);
    do_read(7'h30, 8'h00, 4);
    // R3 wake and fill burst
    do_write(7'h30, 1'b1, 8'h00, 3, 8'h81, 8'h5A, 8'h33, 8'h00);
    // R5 R6 R9 read across status and wrap
    do_read(7'h30, 8'h00, 6);
    // R6 write to status ignored, wrap into command
    do_write(7'h30, 1'b1, 8'h03, 2, 8'hFF, 8'h83, 8'h00, 8'h00);
    do_read(7'h30, 8'h03, 2);
    // R5 pointers above 3
    do_write(7'h30, 1'b1, 8'h04, 3, 8'h11, 8'h22, 8'h33, 8'h00);
    do_read(7'h30, 8'h04, 3);
    do_write(7'h30, 1'b1, 8'hFF, 2, 8'h44, 8'h85, 8'h00, 8'h00);
    // R8 enter shutdown then try dim/aux in same burst (R7)
    do_write(7'h30, 1'b1, 8'h00, 3, 8'h12, 8'h77, 8'h66, 8'h00);
    do_read(7'h30, 8'h01, 3);
    // R2 wrong address and other straps
    do_write(7'h31, 1'b0, 8'h00, 0, 8'h00, 8'h00, 8'h00, 8'h00);
    strap = 2'b10;
    tick(4);
    do_write(7'h30, 1'b0, 8'h00, 0, 8'h00, 8'h00, 8'h00, 8'h00);
    do_write(7'h32, 1'b1, 8'h00, 2, 8'h90, 8'h21, 8'h00, 8'h00);
    strap = 2'b11;
    tick(4);
    do_read(7'h33, 8'h00, 2);

    for (int t = 0; t < 45; t++) begin
      bit wrong;
      int n;
      logic [7:0] p, d0;
      strap = 2'($urandom_range(0, 3));
      stat_in = 8'($urandom);
      tick(4);
      wrong = ($urandom_range(0, 7) == 0);
      dev = 7'h30 + 7'(strap);
      if (wrong) dev = 7'h30 + 7'(strap ^ 2'($urandom_range(1, 3)));
      p = 8'($urandom_range(0, 5));
      n = $urandom_range(1, 4);
      d0 = 8'($urandom);
      if (p == 8'h00) d0[7] = ($urandom_range(0, 3) != 0);
      if (wrong)
        do_write(dev, 1'b0, p, 0, 8'h00, 8'h00, 8'h00, 8'h00);
      else if ($urandom_range(0, 1) == 0)
        do_write(dev, 1'b1, p, n, d0, 8'($urandom), 8'($urandom), 8'($urandom));
      else
        do_read(dev, p, n + 1);
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule